// File: doc/BRIEF.md
# Smart Card Character Error-Signal Timer

This block watches the single shared data line of a half-duplex smart card link. It places the error-signal events of each character at fixed fractions of an elementary time unit (etu). The etu length comes from an input that gives the number of clock cycles per etu. Every time point is taken from the falling edge that opens the character, at a resolution of half an etu (`etu_cycles / 2` cycles).

In the receiving role, the block samples the character in the middle of each bit and checks even parity over the data and parity bits. On a parity failure it pulls the line low for one etu, starting 10.5 etu after the start edge.

In the transmitting role, the block samples the line 11.0 etu after the start edge. If the line is low there, it raises a one-cycle retransmit flag.

Falling edges that arrive after the start edge and before the detector is armed again never open a new character. This covers a late error signal from the far end, for example one arriving at 10.68 etu. The detector arms again only after the line has been high for one full etu.

Top module: `scnack_nack_timer`

## Requirements
- R1: While reset is held, and in the first cycle after reset, `line_drive_low`, `nack_detected` and `rx_done` are 0 and `rx_data` is 0. After reset, a character is accepted only after the line has been high for one etu.
- R2: In the receiving role (`role_tx`=0), bit k (k=1..8 data, least significant first; k=9 parity) is sampled at (k+0.5) etu after the start edge. The sample point is the clock edge (2k+1)*etu/2 cycles after the edge that saw the line low. `rx_done` pulses for one cycle in the cycle after the parity sample, and `rx_data` holds the byte.
- R3: `rx_parity_err` is 1 when the nine received bits (8 data plus parity) hold an odd number of ones, and 0 otherwise. It is valid with `rx_done`.
- R4: In the receiving role with a parity error, `line_drive_low` is 1 for exactly one etu. It rises in the cycle after the edge 21*etu/2 cycles past the start edge and falls in the cycle after the edge 23*etu/2 cycles past it.
- R5: `line_drive_low` stays 0 when parity is correct, and always in the transmitting role, even if the line carries a bad parity bit.
- R6: In the transmitting role (`role_tx`=1), the line is sampled at the edge 22*etu/2 cycles after the start edge. A low sample gives a one-cycle `nack_detected` pulse in the next cycle. A high sample gives none, including when the line falls one cycle later.
- R7: Falling edges after a start edge and before re-arming are ignored, including an error signal that begins 10.68 etu after the start. A character that begins one etu after that error signal ends is received correctly.
- R8: The start detector re-arms only after the line has been high for one etu once the character window (11.5 etu) closes. A low level during that etu restarts the wait, and a short low pulse there opens no character.
- R9: All time points scale with `etu_cycles`, which must be even and at least 4 and held stable during a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| etu_cycles | input | ETU_W | Clock cycles per etu (even, at least 4) |
| role_tx | input | 1 | 1: transmitting role, 0: receiving role; taken at the start edge |
| line_in | input | 1 | Synchronized level of the shared data line |
| line_drive_low | output | 1 | Pull the shared line low (error signal) |
| nack_detected | output | 1 | One-cycle pulse: error signal seen after a sent character |
| rx_done | output | 1 | One-cycle pulse: received character complete |
| rx_data | output | DATA_BITS | Last received data byte |
| rx_parity_err | output | 1 | Parity result of the last received character |

## Verification
The assertions check every cycle that both pulses last one cycle, and that the error drive appears only inside a character window and only in the receiving role. They also check that nothing but the window's end lets the block leave that window, so a mid-window edge can never restart it, and that a low line during the guard etu always sends the detector back to waiting. Only the bench scenarios can show that the drive window and sample point land on the exact half-etu cycles for several etu values. Likewise, only the bench can show that a late error signal at 10.68 etu or a guard-time glitch leaves the next character intact, and that the bits are gathered in the right order with the right parity verdict.

// File: rtl/scnack_pkg.sv
package scnack_pkg;

    // Line-watch state of the start detector
    typedef enum logic [1:0] {
        ST_WAITHI = 2'd0,   // wait for the line to be high
        ST_GUARD  = 2'd1,   // line high, counting one etu before re-arming
        ST_IDLE   = 2'd2,   // armed: next low level opens a character
        ST_FRAME  = 2'd3    // inside a character window
    } line_st_e;

endpackage

// File: rtl/scnack_half_timer.sv
module scnack_half_timer #(
    parameter int CNT_W = 11,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] half_len,
    output logic             tick,
    output logic [IDX_W-1:0] idx
);

    typedef struct packed {
        logic [CNT_W-1:0] cyc;
        logic [IDX_W-1:0] idx;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign tick = run && !clear && (tmr_q.cyc == half_len);
    assign idx  = tmr_q.idx;

    always_comb begin
        tmr_d = tmr_q;
        if (clear) begin
            tmr_d.cyc = CNT_W'(1);
            tmr_d.idx = '0;
        end else if (run) begin
            if (tick) begin
                tmr_d.cyc = CNT_W'(1);
                if (tmr_q.idx != '1) begin
                    tmr_d.idx = tmr_q.idx + IDX_W'(1);
                end
            end else begin
                tmr_d.cyc = tmr_q.cyc + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && half_len > CNT_W'(1)) |=> !tick); // R9

endmodule

// File: rtl/scnack_bit_sampler.sv
module scnack_bit_sampler #(
    parameter int NBITS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             take,
    input  logic             bit_in,
    output logic [NBITS-1:0] word_next
);

    logic [NBITS-1:0] sh_d, sh_q;

    // new bit enters at the top, so the first bit ends up at position 0
    assign word_next = {bit_in, sh_q[NBITS-1:1]};

    always_comb begin
        sh_d = sh_q;
        if (clear) begin
            sh_d = '0;
        end else if (take) begin
            sh_d = word_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

endmodule

// File: rtl/scnack_nack_timer.sv
module scnack_nack_timer
    import scnack_pkg::*;
#(
    parameter int ETU_W     = 12,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ETU_W-1:0]     etu_cycles,
    input  logic                 role_tx,
    input  logic                 line_in,
    output logic                 line_drive_low,
    output logic                 nack_detected,
    output logic                 rx_done,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_parity_err
);

    localparam int HALF_W  = ETU_W - 1;
    localparam int NBITS   = DATA_BITS + 1;
    localparam int END_INT = 2 * DATA_BITS + 6;
    localparam int IDX_W   = $clog2(END_INT + 2);

    // half-etu index seen at the tick that reaches point (idx+1) half-etus
    localparam logic [IDX_W-1:0] IDX_FIRST  = IDX_W'(2);                  // 1.5 etu
    localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(2 * NBITS);          // parity sample
    localparam logic [IDX_W-1:0] IDX_DRV_ON = IDX_W'(2 * DATA_BITS + 4);  // 10.5 etu
    localparam logic [IDX_W-1:0] IDX_TX_SMP = IDX_W'(2 * DATA_BITS + 5);  // 11.0 etu
    localparam logic [IDX_W-1:0] IDX_END    = IDX_W'(END_INT);            // 11.5 etu
    localparam logic [IDX_W-1:0] IDX_GUARD  = IDX_W'(1);                  // 1 etu

    typedef struct packed {
        line_st_e             st;
        logic                 role_tx;
        logic                 perr;
        logic                 drive;
        logic                 nack;
        logic                 done;
        logic [DATA_BITS-1:0] data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             tmr_clear, tmr_run, tick;
    logic [IDX_W-1:0] idx;
    logic             smp_clear, smp_take;
    logic [NBITS-1:0] word_next;
    logic [HALF_W-1:0] half_len;

    assign half_len = etu_cycles[ETU_W-1:1];

    scnack_half_timer #(
        .CNT_W (HALF_W),
        .IDX_W (IDX_W)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (tmr_clear),
        .run      (tmr_run),
        .half_len (half_len),
        .tick     (tick),
        .idx      (idx)
    );

    scnack_bit_sampler #(
        .NBITS (NBITS)
    ) sampler_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (smp_clear),
        .take      (smp_take),
        .bit_in    (line_in),
        .word_next (word_next)
    );

    // bit centres fall on even indices between the first data bit and parity
    assign smp_take = (ctl_q.st == ST_FRAME) && tick && !idx[0] &&
                      (idx >= IDX_FIRST) && (idx <= IDX_LAST);

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.nack = 1'b0;
        ctl_d.done = 1'b0;
        tmr_clear  = 1'b0;
        tmr_run    = 1'b0;
        smp_clear  = 1'b0;
        unique case (ctl_q.st)
            ST_WAITHI: begin
                if (line_in) begin
                    ctl_d.st  = ST_GUARD;
                    tmr_clear = 1'b1;
                end
            end
            ST_GUARD: begin
                tmr_run = 1'b1;
                if (!line_in) begin
                    ctl_d.st = ST_WAITHI;
                end else if (tick && idx == IDX_GUARD) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (!line_in) begin
                    ctl_d.st      = ST_FRAME;
                    ctl_d.role_tx = role_tx;
                    ctl_d.perr    = 1'b0;
                    ctl_d.drive   = 1'b0;
                    tmr_clear     = 1'b1;
                    smp_clear     = 1'b1;
                end
            end
            ST_FRAME: begin
                tmr_run = 1'b1;
                if (tick) begin
                    if (idx == IDX_LAST && !ctl_q.role_tx) begin
                        ctl_d.done = 1'b1;
                        ctl_d.data = word_next[DATA_BITS-1:0];
                        ctl_d.perr = ^word_next;
                    end
                    if (idx == IDX_DRV_ON && !ctl_q.role_tx && ctl_q.perr) begin
                        ctl_d.drive = 1'b1;
                    end
                    if (idx == IDX_TX_SMP && ctl_q.role_tx) begin
                        ctl_d.nack = !line_in;
                    end
                    if (idx == IDX_END) begin
                        ctl_d.drive = 1'b0;
                        ctl_d.st    = ST_WAITHI;
                    end
                end
            end
            default: ctl_d.st = ST_WAITHI;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_WAITHI;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign line_drive_low = ctl_q.drive;
    assign nack_detected  = ctl_q.nack;
    assign rx_done        = ctl_q.done;
    assign rx_data        = ctl_q.data;
    assign rx_parity_err  = ctl_q.perr;

    AST_NACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        nack_detected |=> !nack_detected); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done); // R2
    AST_DRIVE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        line_drive_low |-> (ctl_q.st == ST_FRAME)); // R4
    AST_DRIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_drive_low) |=> line_drive_low); // R4
    AST_DRIVE_RX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        line_drive_low |-> !ctl_q.role_tx); // R5
    AST_WINDOW_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_FRAME && !(tick && idx == IDX_END)) |=> (ctl_q.st == ST_FRAME)); // R7
    AST_GUARD_LOW_REWAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_GUARD && !line_in) |=> (ctl_q.st == ST_WAITHI)); // R8

endmodule

// File: tb/scnack_nack_timer_tb_top.sv
module scnack_nack_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] etu_cycles = 12'd16;
    logic        role_tx = 1'b0;
    logic        card_lvl = 1'b1;
    logic        line_w;
    logic        line_drive_low, nack_detected, rx_done, rx_parity_err;
    logic [7:0]  rx_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    // wired-AND line: far end level and the block's own pull-down
    assign line_w = card_lvl & ~line_drive_low;

    scnack_nack_timer #(.ETU_W(12), .DATA_BITS(8)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .etu_cycles     (etu_cycles),
        .role_tx        (role_tx),
        .line_in        (line_w),
        .line_drive_low (line_drive_low),
        .nack_detected  (nack_detected),
        .rx_done        (rx_done),
        .rx_data        (rx_data),
        .rx_parity_err  (rx_parity_err)
    );

    typedef struct packed {
        logic [11:0] etu;
        logic        role;
        logic [7:0]  data;
        logic        bad;
        logic [11:0] pull_at;
        logic [11:0] pull_len;
        logic [7:0]  span;     // observation length in half-etus
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{12'd16, 1'b0, 8'hA5, 1'b0, 12'd0,   12'd0,  8'd30}, // R2 R5 good parity
        '{12'd16, 1'b0, 8'h3C, 1'b1, 12'd0,   12'd0,  8'd30}, // R3 R4
        '{12'd12, 1'b0, 8'h01, 1'b1, 12'd0,   12'd0,  8'd30}, // R9
        '{12'd16, 1'b1, 8'h5A, 1'b0, 12'd0,   12'd0,  8'd30}, // R6 no error signal
        '{12'd16, 1'b1, 8'h81, 1'b0, 12'd168, 12'd16, 8'd30}, // R6 signal at 10.5 etu
        '{12'd16, 1'b1, 8'h7E, 1'b0, 12'd171, 12'd16, 8'd26}, // R7 signal at 10.68 etu
        '{12'd16, 1'b0, 8'hFF, 1'b1, 12'd0,   12'd0,  8'd30}, // R7 follows at once
        '{12'd20, 1'b1, 8'h00, 1'b1, 12'd0,   12'd0,  8'd30}, // R5 tx role bad parity
        '{12'd10, 1'b0, 8'hC3, 1'b1, 12'd0,   12'd0,  8'd30}, // R9
        '{12'd16, 1'b1, 8'h11, 1'b0, 12'd176, 12'd16, 8'd30}, // R6 falls on sample edge
        '{12'd16, 1'b1, 8'h22, 1'b0, 12'd177, 12'd16, 8'd30}, // R6 falls one cycle late
        '{12'd16, 1'b0, 8'h96, 1'b0, 12'd187, 12'd2,  8'd48}  // R8 glitch in guard
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic line_level(input vec_t v, input int n);
        int  e = int'(v.etu);
        int  j = n / e;
        logic b;
        if (j == 0)      b = 1'b0;
        else if (j <= 8) b = v.data[j-1];
        else if (j == 9) b = (^v.data) ^ v.bad;
        else             b = 1'b1;
        if (v.pull_len != 0 && n >= int'(v.pull_at) && n < int'(v.pull_at) + int'(v.pull_len))
            b = 1'b0;
        return b;
    endfunction

    task automatic run_char(input vec_t v, input int idx);
        int h = int'(v.etu) / 2;
        int drv_bad = 0, nack_bad = 0, done_bad = 0, nack_seen = 0, done_seen = 0;
        bit nack_exp_any;
        nack_exp_any = v.role && v.pull_len != 0 &&
                       (22*h >= int'(v.pull_at)) && (22*h < int'(v.pull_at) + int'(v.pull_len));
        for (int n = 0; n < int'(v.span) * h; n++) begin
            @(negedge clk);
            if (n == 0) begin
                etu_cycles = v.etu;
                role_tx    = v.role;
            end
            if (n >= 1) begin
                int e = n - 1;
                bit exp_drv  = !v.role && v.bad && e >= 21*h && e < 23*h;
                bit exp_nack = nack_exp_any && e == 22*h;
                bit exp_done = !v.role && e == 19*h;
                if (line_drive_low !== exp_drv) drv_bad++;
                if (nack_detected !== exp_nack) nack_bad++;
                if (nack_detected) nack_seen++;
                if (rx_done !== exp_done) done_bad++;
                if (rx_done) begin
                    done_seen++;
                    if (rx_data !== v.data || rx_parity_err !== v.bad) done_bad++;
                end
            end
            card_lvl = line_level(v, n);
        end
        card_lvl = 1'b1;
        chk(drv_bad == 0, "R4/R5", $sformatf("vec %0d drive window mismatches", idx), drv_bad, 0);
        chk(nack_bad == 0, "R6/R7", $sformatf("vec %0d nack pulses", idx), nack_seen,
            nack_exp_any ? 1 : 0);
        chk(done_bad == 0, "R2/R3/R8", $sformatf("vec %0d rx done/data/parity mismatches", idx),
            done_bad, 0);
        if (v.role == 0 && done_seen == 1) begin
            // R2 R3 byte and parity verdict already compared at the done pulse
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 outputs idle under reset
        chk(line_drive_low == 0 && nack_detected == 0 && rx_done == 0 && rx_data == 0,
            "R1", "outputs in reset", {line_drive_low, nack_detected, rx_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(line_drive_low == 0 && nack_detected == 0 && rx_done == 0,
            "R1", "outputs after reset", {line_drive_low, nack_detected, rx_done}, 0);
        repeat (40) @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            run_char(VECS[i], i);
        end

        // R1 reset during the error drive releases the line at once
        etu_cycles = 12'd16;
        role_tx    = 1'b0;
        for (int n = 0; n < 21*8 + 4; n++) begin
            card_lvl = line_level(VECS[1], n);
            @(negedge clk);
        end
        chk(line_drive_low == 1'b1, "R4", "drive active before mid-window reset",
            int'(line_drive_low), 1);
        rst_n = 1'b0;
        #1;
        chk(line_drive_low == 1'b0, "R1", "drive released by reset", int'(line_drive_low), 0);
        card_lvl = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        run_char(VECS[0], 100);   // R1 recovers after the guard etu

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule